// File: doc/BRIEF.md
# Write-Back Cache Request Sequencer

This controller walks the request at the head of a cache request queue through its whole life in a write-back, write-allocate cache. In the cycle a new head is presented, the controller reads the tag lookup result. Each request then falls into one of three cases:

- a hit;
- a miss whose victim line is clean;
- a miss whose victim line is dirty and must be written back first.

For a miss, the controller issues the victim write-back and the line-fill request to memory. It then counts the returned data beats and hands read data to the CPU. When the request is finished it pops the queue for one cycle. Only the queue head is active, so there is at most one request in flight at any time.

A read miss forwards its data to the CPU as soon as the first beat of the line returns, without waiting for the rest. The miss then completes by one of two routes: the CPU may accept the data before the line has finished, or the line may finish before the CPU accepts. Each route has its own waiting state, and the pop waits for both events.

Both outward interfaces use valid/ready:

- **Memory request port.** While it waits for `mem_req_ready`, the sequencer holds `mem_req_valid`, `mem_req_wb` and `mem_req_addr` steady.
- **CPU data port.** While it waits for `cpu_ready`, the sequencer holds `cpu_valid` high.

A transfer takes place only in a cycle where both valid and ready are high. Back-pressure on either port only stretches the request's life; it never drops an event. Returned data beats come with no back-pressure: each `mem_beat` pulse is one beat.

Top module: `wb_req_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the controller returns to idle. After that edge, `hd_pop`, `wr_merge`, `mem_req_valid` and `cpu_valid` are low until a request is presented.
- R2: A read hit raises `cpu_valid` one cycle after the head is presented and holds it until `cpu_ready`. `hd_pop` pulses in the cycle of the CPU handshake. The dirty flag of the lookup has no effect on a hit.
- R3: A write hit pulses `hd_pop` and `wr_merge` together, in the same cycle the head is presented in idle. No memory request is made.
- R4: On a read miss with a clean victim, a fill request (`mem_req_wb`=0, `mem_req_addr` = request address) is raised one cycle after presentation and held until accepted. `cpu_valid` stays low until the first data beat has arrived.
- R5: `cpu_valid` for a read miss rises in the cycle after the first returned beat.
- R6: If the CPU accepts a read miss's data before the last of the `BEATS` beats has arrived, `cpu_valid` drops. `hd_pop` then pulses in the cycle of the last beat.
- R7: If all `BEATS` beats of a read miss arrive before the CPU accepts, `cpu_valid` stays high. `hd_pop` then pulses in the cycle of the CPU handshake.
- R8: On a read miss with a dirty victim, a write-back request (`mem_req_wb`=1, `mem_req_addr` = victim address) comes first. The fill request is raised only in the cycle after the write-back is accepted. The rest follows R4 to R7.
- R9: A write miss with a clean victim issues the fill request. `hd_pop` and `wr_merge` then pulse together in the cycle of the last of the `BEATS` beats. `cpu_valid` never rises.
- R10: A write miss with a dirty victim issues the write-back, then the fill, then completes as in R9.
- R11: A handshake completes only with both valid and ready high. Beats, `mem_req_ready` and `cpu_ready` have no effect while no fill is outstanding. In particular, beats in idle do not count toward a later line.
- R12: If the CPU handshake and the last beat of a read miss fall in the same cycle, `hd_pop` pulses in that cycle.
- R13: After any pop, the controller is idle in the next cycle. Events occur in request order: write-back, fill, CPU transfer, pop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hd_valid | input | 1 | Queue head holds a request |
| hd_write | input | 1 | Head is a write (1) or a read (0) |
| hd_addr | input | AW | Head request address |
| hd_pop | output | 1 | One-cycle strobe: remove head from the queue |
| lkp_hit | input | 1 | Tag lookup hit for the head address |
| lkp_dirty | input | 1 | Victim line chosen for the miss is dirty |
| lkp_victim_addr | input | AW | Address of the victim line |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_wb | output | 1 | 1 = victim write-back, 0 = line fill |
| mem_req_addr | output | AW | Memory request address |
| mem_beat | input | 1 | One returned fill data beat |
| cpu_valid | output | 1 | Read data available to the CPU |
| cpu_ready | input | 1 | CPU accepts the read data |
| wr_merge | output | 1 | One-cycle strobe: merge write data into the line and set its dirty bit |

## Verification
The cycle a head is presented is cycle 0. Request outputs and `cpu_valid` for a hit are due in cycle 1. `cpu_valid` for a miss is due in the cycle after the first beat. A pop is due in the very cycle of its completing event. The stimulus task drives inputs just after each rising edge. In every cycle of a request it compares `cpu_valid`, the memory request fields, `hd_pop` and `wr_merge` at the falling edge against values it tracks from the handshakes and beats it has itself produced. A separate scoreboard checks the order and the addresses of the completed events.

// File: rtl/wbseq_pkg.sv
package wbseq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_HIT,
    ST_RD_EVICT,
    ST_RD_FILL,
    ST_RD_WAIT,
    ST_RD_FWD,
    ST_RD_DONE_CPU,
    ST_RD_DONE_LINE,
    ST_WR_EVICT,
    ST_WR_FILL,
    ST_WR_WAIT
  } seq_state_e;

  typedef enum logic [2:0] {
    CL_NONE,
    CL_RD_HIT,
    CL_RD_MISS,
    CL_RD_EVICT,
    CL_WR_HIT,
    CL_WR_MISS,
    CL_WR_EVICT
  } req_class_e;

endpackage

// File: rtl/wbseq_classify.sv
module wbseq_classify
  import wbseq_pkg::*;
(
  input  logic       valid_i,
  input  logic       is_write_i,
  input  logic       hit_i,
  input  logic       dirty_i,
  output req_class_e cls_o
);
  always_comb begin
    if (!valid_i)          cls_o = CL_NONE;
    else if (is_write_i) begin
      if (hit_i)           cls_o = CL_WR_HIT;
      else if (dirty_i)    cls_o = CL_WR_EVICT;
      else                 cls_o = CL_WR_MISS;
    end else begin
      if (hit_i)           cls_o = CL_RD_HIT;
      else if (dirty_i)    cls_o = CL_RD_EVICT;
      else                 cls_o = CL_RD_MISS;
    end
  end
endmodule

// File: rtl/wbseq_beat_ctr.sv
module wbseq_beat_ctr #(
  parameter int BEATS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic count_en_i,
  input  logic beat_i,
  output logic first_o,
  output logic last_o
);
  localparam int CW = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(BEATS - 1);

  logic [CW-1:0] cnt_q;
  logic          take;

  assign take    = count_en_i && beat_i;
  assign first_o = take && (cnt_q == '0);
  assign last_o  = take && (cnt_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst || clear_i)  cnt_q <= '0;
    else if (last_o)     cnt_q <= '0;
    else if (take)       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wbseq_fsm.sv
module wbseq_fsm
  import wbseq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  req_class_e    cls_i,
  input  logic [AW-1:0] hd_addr_i,
  input  logic [AW-1:0] victim_i,
  input  logic          mem_ready_i,
  input  logic          cpu_ready_i,
  input  logic          first_beat_i,
  input  logic          last_beat_i,
  output logic          pop_o,
  output logic          merge_o,
  output logic          mem_valid_o,
  output logic          mem_wb_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          cpu_valid_o,
  output logic          count_en_o,
  output logic          fill_taken_o
);
  seq_state_e    state_q, state_d;
  logic [AW-1:0] addr_q, victim_q;
  logic          mem_hs, cpu_hs;

  assign mem_valid_o  = (state_q == ST_RD_EVICT) || (state_q == ST_RD_FILL) ||
                        (state_q == ST_WR_EVICT) || (state_q == ST_WR_FILL);
  assign mem_wb_o     = (state_q == ST_RD_EVICT) || (state_q == ST_WR_EVICT);
  assign mem_addr_o   = mem_wb_o ? victim_q : addr_q;
  assign cpu_valid_o  = (state_q == ST_RD_HIT) || (state_q == ST_RD_FWD) ||
                        (state_q == ST_RD_DONE_LINE);
  assign count_en_o   = (state_q == ST_RD_WAIT) || (state_q == ST_RD_FWD) ||
                        (state_q == ST_RD_DONE_CPU) || (state_q == ST_WR_WAIT);
  assign mem_hs       = mem_valid_o && mem_ready_i;
  assign cpu_hs       = cpu_valid_o && cpu_ready_i;
  assign fill_taken_o = mem_hs && !mem_wb_o;

  always_comb begin
    state_d = state_q;
    pop_o   = 1'b0;
    merge_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        unique case (cls_i)
          CL_RD_HIT:   state_d = ST_RD_HIT;
          CL_RD_MISS:  state_d = ST_RD_FILL;
          CL_RD_EVICT: state_d = ST_RD_EVICT;
          CL_WR_MISS:  state_d = ST_WR_FILL;
          CL_WR_EVICT: state_d = ST_WR_EVICT;
          CL_WR_HIT: begin
            pop_o   = 1'b1;
            merge_o = 1'b1;
          end
          default: ;
        endcase
      end
      ST_RD_HIT: if (cpu_hs) begin
        pop_o   = 1'b1;
        state_d = ST_IDLE;
      end
      ST_RD_EVICT: if (mem_hs) state_d = ST_RD_FILL;
      ST_RD_FILL:  if (mem_hs) state_d = ST_RD_WAIT;
      ST_RD_WAIT: begin
        if (last_beat_i)       state_d = ST_RD_DONE_LINE;
        else if (first_beat_i) state_d = ST_RD_FWD;
      end
      ST_RD_FWD: begin
        if (cpu_hs && last_beat_i) begin
          pop_o   = 1'b1;
          state_d = ST_IDLE;
        end else if (cpu_hs)   state_d = ST_RD_DONE_CPU;
        else if (last_beat_i)  state_d = ST_RD_DONE_LINE;
      end
      ST_RD_DONE_CPU: if (last_beat_i) begin
        pop_o   = 1'b1;
        state_d = ST_IDLE;
      end
      ST_RD_DONE_LINE: if (cpu_hs) begin
        pop_o   = 1'b1;
        state_d = ST_IDLE;
      end
      ST_WR_EVICT: if (mem_hs) state_d = ST_WR_FILL;
      ST_WR_FILL:  if (mem_hs) state_d = ST_WR_WAIT;
      ST_WR_WAIT: if (last_beat_i) begin
        pop_o   = 1'b1;
        merge_o = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      victim_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && cls_i != CL_NONE) begin
        addr_q   <= hd_addr_i;
        victim_q <= victim_i;
      end
    end
  end

  // R13: a pop from a busy state lands back in idle
  assert_pop_to_idle_R13: assert property (@(posedge clk) disable iff (rst)
    (pop_o && state_q != ST_IDLE) |=> state_q == ST_IDLE);

  // R11: an unaccepted memory request keeps its fields
  assert_mem_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (mem_valid_o && !mem_ready_i) |=>
      (mem_valid_o && $stable(mem_addr_o) && $stable(mem_wb_o)));

  // R8: an accepted write-back is followed by the fill request
  assert_wb_then_fill_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_valid_o && mem_ready_i && mem_wb_o) |=> (mem_valid_o && !mem_wb_o));

  // R2: CPU data stays offered until taken
  assert_cpu_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid_o && !cpu_ready_i) |=> cpu_valid_o);

  // R5: CPU data appears only after a hit lookup or a first beat
  assert_cpu_after_data_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_valid_o) |-> ($past(first_beat_i) || $past(state_q == ST_IDLE)));

  // R3: merge strobe only accompanies a pop
  assert_merge_with_pop_R3: assert property (@(posedge clk) disable iff (rst)
    merge_o |-> pop_o);

endmodule

// File: rtl/wb_req_sequencer.sv
module wb_req_sequencer
  import wbseq_pkg::*;
#(
  parameter int AW    = 32,
  parameter int BEATS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hd_valid,
  input  logic          hd_write,
  input  logic [AW-1:0] hd_addr,
  output logic          hd_pop,
  input  logic          lkp_hit,
  input  logic          lkp_dirty,
  input  logic [AW-1:0] lkp_victim_addr,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_wb,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_beat,
  output logic          cpu_valid,
  input  logic          cpu_ready,
  output logic          wr_merge
);
  req_class_e cls;
  logic       count_en, fill_taken, first_beat, last_beat;

  wbseq_classify u_cls (
    .valid_i    (hd_valid),
    .is_write_i (hd_write),
    .hit_i      (lkp_hit),
    .dirty_i    (lkp_dirty),
    .cls_o      (cls)
  );

  wbseq_beat_ctr #(.BEATS(BEATS)) u_beats (
    .clk        (clk),
    .rst        (rst),
    .clear_i    (fill_taken),
    .count_en_i (count_en),
    .beat_i     (mem_beat),
    .first_o    (first_beat),
    .last_o     (last_beat)
  );

  wbseq_fsm #(.AW(AW)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .cls_i        (cls),
    .hd_addr_i    (hd_addr),
    .victim_i     (lkp_victim_addr),
    .mem_ready_i  (mem_req_ready),
    .cpu_ready_i  (cpu_ready),
    .first_beat_i (first_beat),
    .last_beat_i  (last_beat),
    .pop_o        (hd_pop),
    .merge_o      (wr_merge),
    .mem_valid_o  (mem_req_valid),
    .mem_wb_o     (mem_req_wb),
    .mem_addr_o   (mem_req_addr),
    .cpu_valid_o  (cpu_valid),
    .count_en_o   (count_en),
    .fill_taken_o (fill_taken)
  );
endmodule

// File: tb/wb_req_sequencer_tb.sv
`timescale 1ns/1ps
module wb_req_sequencer_tb;
  localparam int AW    = 16;
  localparam int BEATS = 4;

  typedef enum int {EV_WB, EV_FILL, EV_CPU, EV_POP, EV_POPM} ev_kind_e;
  typedef struct {
    ev_kind_e    kind;
    logic [AW-1:0] addr;
    string       tag;
  } ev_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hd_valid = 0, hd_write = 0, lkp_hit = 0, lkp_dirty = 0;
  logic [AW-1:0] hd_addr = '0, lkp_victim_addr = '0;
  logic mem_req_ready = 0, mem_beat = 0, cpu_ready = 0;
  logic hd_pop, mem_req_valid, mem_req_wb, cpu_valid, wr_merge;
  logic [AW-1:0] mem_req_addr;

  int n_checks = 0;
  int n_fail   = 0;
  ev_t sb_q[$];

  always #10 clk = ~clk;

  wb_req_sequencer #(.AW(AW), .BEATS(BEATS)) u_dut (
    .clk(clk), .rst(rst),
    .hd_valid(hd_valid), .hd_write(hd_write), .hd_addr(hd_addr), .hd_pop(hd_pop),
    .lkp_hit(lkp_hit), .lkp_dirty(lkp_dirty), .lkp_victim_addr(lkp_victim_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_wb(mem_req_wb), .mem_req_addr(mem_req_addr),
    .mem_beat(mem_beat), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
    .wr_merge(wr_merge)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // scoreboard monitor: compares completed events with expected order
  task automatic got(input ev_kind_e k, input logic [AW-1:0] a);
    ev_t e;
    if (sb_q.size() == 0) begin
      check(1'b0, "R13 unexpected event", k, -1);
    end else begin
      e = sb_q.pop_front();
      check(e.kind == k, e.tag, k, e.kind);
      if (k == EV_WB || k == EV_FILL) check(a === e.addr, e.tag, a, e.addr);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (mem_req_valid && mem_req_ready) got(mem_req_wb ? EV_WB : EV_FILL, mem_req_addr);
      if (cpu_valid && cpu_ready) got(EV_CPU, '0);
      if (hd_pop) got(wr_merge ? EV_POPM : EV_POP, '0);
    end
  end

  function automatic ev_t mk(input ev_kind_e k, input logic [AW-1:0] a, input string t);
    ev_t e;
    e.kind = k; e.addr = a; e.tag = t;
    return e;
  endfunction

  // driver: presents one head and plays memory and CPU around it
  task automatic run(input bit wr, input bit hit, input bit dirty,
                     input logic [AW-1:0] a, input logic [AW-1:0] v,
                     input int mwait, input int bgap, input int cwait);
    bit evict, wb_acc, fill_acc, cpu_done, first_seen, done;
    bit exp_cv, exp_mv, exp_pop, beat_now, cpu_now, mem_hs;
    int cyc, beats, gapc, mcnt, ccnt, nb;
    string ptag;
    evict = !hit && dirty;
    if (evict) sb_q.push_back(mk(EV_WB, v, wr ? "R10" : "R8"));
    if (!hit)  sb_q.push_back(mk(EV_FILL, a, wr ? "R9" : "R4"));
    if (!wr)   sb_q.push_back(mk(EV_CPU, '0, "R2"));
    sb_q.push_back(mk(wr ? EV_POPM : EV_POP, '0, "R13"));
    wb_acc = !evict; fill_acc = hit; cpu_done = 0; first_seen = 0; done = 0;
    cyc = 0; beats = 0; gapc = 0; mcnt = 0; ccnt = 0;
    @(posedge clk); #1;
    hd_valid = 1; hd_write = wr; hd_addr = a; lkp_hit = hit; lkp_dirty = dirty;
    lkp_victim_addr = v;
    for (int k = 0; k < 400 && !done; k++) begin
      mem_req_ready = mem_req_valid && (mcnt >= mwait);
      mem_beat      = fill_acc && !hit && (beats < BEATS) && (gapc >= bgap);
      cpu_ready     = cpu_valid && (ccnt >= cwait);
      @(negedge clk);
      exp_cv = !wr && !cpu_done && (hit ? (cyc >= 1) : first_seen);
      check(cpu_valid === exp_cv, hit ? "R2" : (wr ? "R9" : "R5"), cpu_valid, exp_cv);
      exp_mv = !hit && (cyc >= 1) && !fill_acc;
      check(mem_req_valid === exp_mv, "R4", mem_req_valid, exp_mv);
      if (exp_mv) begin
        check(mem_req_wb === !wb_acc, wr ? "R10" : "R8", mem_req_wb, !wb_acc);
        check(mem_req_addr === (wb_acc ? a : v), "R8", mem_req_addr, wb_acc ? a : v);
      end
      beat_now = mem_beat;
      cpu_now  = exp_cv && cpu_ready;
      mem_hs   = exp_mv && mem_req_ready;
      nb       = beats + (beat_now ? 1 : 0);
      if (wr) begin
        exp_pop = hit ? (cyc == 0) : (nb == BEATS);
        ptag = hit ? "R3" : (evict ? "R10" : "R9");
      end else if (hit) begin
        exp_pop = cpu_now;
        ptag = "R2";
      end else begin
        exp_pop = (cpu_done || cpu_now) && (nb == BEATS);
        ptag = (cpu_now && beat_now && nb == BEATS) ? "R12" : (cpu_done ? "R6" : "R7");
      end
      check(hd_pop === exp_pop, ptag, hd_pop, exp_pop);
      check(wr_merge === (exp_pop && wr), ptag, wr_merge, exp_pop && wr);
      if (mem_hs) begin
        if (!wb_acc) wb_acc = 1; else fill_acc = 1;
        mcnt = 0;
      end else if (mem_req_valid) mcnt++;
      if (beat_now) begin beats++; gapc = 0; if (!wr) first_seen = 1; end
      else if (fill_acc) gapc++;
      if (cpu_now) cpu_done = 1;
      else if (cpu_valid) ccnt++;
      done = exp_pop;
      cyc++;
      @(posedge clk); #1;
    end
    check(done, "R13 completion", done, 1);
    hd_valid = 0; mem_req_ready = 0; mem_beat = 0; cpu_ready = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    check(!hd_pop && !wr_merge && !mem_req_valid && !cpu_valid, "R1 reset state",
          {hd_pop, wr_merge, mem_req_valid, cpu_valid}, 0);
    // R11: stray beats and readies with nothing outstanding
    @(posedge clk); #1;
    mem_req_ready = 1; cpu_ready = 1;
    for (int i = 0; i < 5; i++) begin
      mem_beat = i[0];
      @(negedge clk);
      check(!hd_pop && !wr_merge && !mem_req_valid && !cpu_valid, "R11 idle inputs ignored",
            {hd_pop, wr_merge, mem_req_valid, cpu_valid}, 0);
      @(posedge clk); #1;
    end
    mem_req_ready = 0; cpu_ready = 0; mem_beat = 0;
    // R11: line must still need all beats after the stray ones
    run(0, 0, 0, 16'h1200, 16'h0000, 1, 1, 12);
    run(0, 1, 0, 16'h0040, 16'h0000, 0, 0, 0);   // R2
    run(0, 1, 1, 16'h0080, 16'h7700, 0, 0, 3);   // R2 dirty ignored
    run(1, 1, 0, 16'h00c0, 16'h0000, 0, 0, 0);   // R3
    run(1, 1, 1, 16'h0100, 16'h7000, 0, 0, 0);   // R3
    run(0, 0, 0, 16'h2000, 16'h0000, 2, 2, 0);   // R6 CPU first
    run(0, 0, 0, 16'h2040, 16'h0000, 0, 0, 8);   // R7 line first
    run(0, 0, 0, 16'h2080, 16'h0000, 1, 1, 5);   // R12 same cycle
    run(0, 0, 1, 16'h3000, 16'h5a40, 1, 0, 1);   // R8
    run(0, 0, 1, 16'h3040, 16'h5a80, 3, 2, 9);   // R8 line first
    run(1, 0, 0, 16'h4000, 16'h0000, 2, 1, 0);   // R9
    run(1, 0, 1, 16'h4040, 16'h6c00, 1, 0, 0);   // R10
    repeat (2) @(posedge clk);
    check(sb_q.size() == 0, "R13 scoreboard drained", sb_q.size(), 0);
    report();
  end
endmodule